// File: doc/BRIEF.md
# Peripheral Freeze Controller

This block drives one freeze line for each of eight timer and engine sources in a chip. Software freezes a source by writing a one to its bit through a set strobe, and releases it by writing a one through a clear strobe. Zero bits in either write leave the state alone. The stored freeze state can be read back at any time on a read data port.

The processor's debug-halt state can override the stored state. A configuration bit, which comes out of reset as one, selects whether a halt freezes every source or only the watchdog. When the bit is zero, a halt freezes the watchdog and the other sources follow the stored state. Outside of a halt, the watchdog cannot be frozen while it runs in its NMI-then-reset mode.

All freeze lines come from flip-flops, so they never glitch. A write, or a change on the halt or mode inputs, shows on the freeze lines after the same rising edge that captures it.

Top module: `frz_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the stored state is all zero, every freeze line is 0, and the debug-freeze configuration bit is 1. A halt with no configuration write therefore freezes all sources.
- R2: When `set_we` is high, each bit of `wdata` that is 1 sets the matching stored bit from the next edge. Bits that are 0 leave their stored bits unchanged.
- R3: When `clr_we` is high, each bit of `wdata` that is 1 clears the matching stored bit from the next edge. Bits that are 0 leave their stored bits unchanged. When neither strobe is high, the stored state does not change.
- R4: When `set_we` and `clr_we` are both high in one cycle, a bit that is 1 in `wdata` ends up cleared.
- R5: While `dbg_halted` is 1 and the configuration bit is 1, all eight freeze lines are 1.
- R6: While `dbg_halted` is 1 and the configuration bit is 0, freeze line 3 (the watchdog) is 1 and every other line equals its stored bit.
- R7: While `dbg_halted` is 0, each line other than the watchdog equals its stored bit. The watchdog line equals stored bit 3 AND NOT `wdog_nmi_mode`.
- R8: Source positions are fixed: bit 0 is the wake-up timer, bit 1 timer 0, bit 2 the radio master clock, bit 3 the watchdog, bit 4 USB, bit 5 DMA, bit 6 timer 1, and bit 7 timer 2. These positions apply to the set port, the clear port, `rdata` and `frz_out` alike.
- R9: `frz_out` is registered. After a rising edge it reflects the stored state updated at that edge and the `dbg_halted` and `wdog_nmi_mode` values sampled at that edge. `rdata` always shows the stored state.
- R10: A write to `cfg_we` with `cfg_wdata` loads the configuration bit at the next edge. The new value governs the freeze lines from the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| set_we | input | 1 | Set strobe: ones in wdata freeze sources |
| clr_we | input | 1 | Clear strobe: ones in wdata release sources |
| wdata | input | 8 | Write data for both strobes |
| rdata | output | 8 | Stored freeze state |
| cfg_we | input | 1 | Write strobe for the debug-freeze configuration bit |
| cfg_wdata | input | 1 | New value of the configuration bit |
| dbg_halted | input | 1 | Processor halted in debug |
| wdog_nmi_mode | input | 1 | Watchdog runs in NMI-then-reset mode |
| frz_out | output | 8 | Registered freeze line per source |

## Verification
The bench writes the same bit through both strobes in one cycle. A design in which set wins would leave that bit frozen when it should be released. It also writes all-zero data through each strobe. A design that loads the data instead of merging it would wipe or overwrite bits that should stay as they were. The bench halts the processor with the configuration bit at both values and with the NMI mode both on and off. A design that leaves the watchdog unfrozen during a halt would fail there, and so would one that lets the NMI mode block the halt override or that ignores the configuration bit. Random streams of writes and input changes then compare every edge against a bench model, which catches any off-by-one latency on the freeze lines.

// File: rtl/frz_pkg.sv
// Shared constants for the freeze controller: source count and bit positions.
package frz_pkg;
    localparam int unsigned FRZ_NUM_SRC  = 8;
    localparam int unsigned FRZ_WAKE_TIM = 0;
    localparam int unsigned FRZ_TIM0     = 1;
    localparam int unsigned FRZ_RADIO    = 2;
    localparam int unsigned FRZ_WDOG     = 3;
    localparam int unsigned FRZ_USB      = 4;
    localparam int unsigned FRZ_DMA      = 5;
    localparam int unsigned FRZ_TIM1     = 6;
    localparam int unsigned FRZ_TIM2     = 7;
endpackage

// File: rtl/frz_state_reg.sv
// Stored freeze state with set/clear merge. Clear wins over set on the same bit.
// Assumes both strobes share one data bus. Synchronous active-low reset.
module frz_state_reg #(
    parameter int unsigned N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic         clr_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] state_nxt,
    output logic [N-1:0] state_q
);
    logic [N-1:0] set_mask;
    logic [N-1:0] clr_mask;

    // Purpose: form merge masks and the next state, with clear applied last.
    always_comb begin
        set_mask  = set_we ? wdata : '0;
        clr_mask  = clr_we ? wdata : '0;
        state_nxt = (state_q | set_mask) & ~clr_mask;
    end

    // Purpose: hold the freeze state.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_nxt;
    end

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (set_we && !clr_we) |=> ((state_q & $past(wdata)) == $past(wdata))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_we && !clr_we) |=> $stable(state_q)); // R3
    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((state_q & $past(wdata)) == '0)); // R4
endmodule

// File: rtl/frz_dbg_cfg.sv
// Debug-freeze configuration bit. It resets to 1 and is loaded by its own strobe.
module frz_dbg_cfg (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_we,
    input  logic cfg_wdata,
    output logic dbg_frz_en
);
    // Purpose: hold the configuration bit.
    always_ff @(posedge clk) begin
        if (!rst_n)      dbg_frz_en <= 1'b1;
        else if (cfg_we) dbg_frz_en <= cfg_wdata;
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (dbg_frz_en == $past(cfg_wdata))); // R10
endmodule

// File: rtl/frz_out_stage.sv
// Combines stored state, debug halt and watchdog mode into the registered freeze lines.
// One slice per source. The watchdog slice uses the halt-always / NMI-block variant.
module frz_out_stage #(
    parameter int unsigned N        = 8,
    parameter int unsigned WDOG_IDX = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] state_nxt,
    input  logic         dbg_halted,
    input  logic         dbg_frz_en,
    input  logic         wdog_nmi_mode,
    output logic [N-1:0] frz_q
);
    logic [N-1:0] frz_d;

    for (genvar i = 0; i < N; i++) begin : g_slice
        if (i == WDOG_IDX) begin : g_wdog
            // Purpose: a halt always freezes the watchdog; otherwise NMI mode blocks it.
            always_comb frz_d[i] = dbg_halted | (state_nxt[i] & ~wdog_nmi_mode);
        end else begin : g_plain
            // Purpose: a halt with the config bit set freezes this source; otherwise follow state.
            always_comb frz_d[i] = (dbg_halted & dbg_frz_en) | state_nxt[i];
        end
    end

    // Purpose: register the lines so they never glitch.
    always_ff @(posedge clk) begin
        if (!rst_n) frz_q <= '0;
        else        frz_q <= frz_d;
    end

    AST_HALT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halted && dbg_frz_en) |=> (frz_q == {N{1'b1}})); // R5
    AST_HALT_WDOG: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_halted |=> frz_q[WDOG_IDX]); // R6
    AST_NMI_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_halted && wdog_nmi_mode) |=> !frz_q[WDOG_IDX]); // R7
endmodule

// File: rtl/frz_ctrl.sv
// Top of the peripheral freeze controller. It instantiates the state register,
// the debug configuration bit and the registered output stage.
module frz_ctrl
    import frz_pkg::*;
#(
    parameter int unsigned NUM_SRC  = FRZ_NUM_SRC,
    parameter int unsigned WDOG_IDX = FRZ_WDOG
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               set_we,
    input  logic               clr_we,
    input  logic [NUM_SRC-1:0] wdata,
    output logic [NUM_SRC-1:0] rdata,
    input  logic               cfg_we,
    input  logic               cfg_wdata,
    input  logic               dbg_halted,
    input  logic               wdog_nmi_mode,
    output logic [NUM_SRC-1:0] frz_out
);
    logic [NUM_SRC-1:0] state_nxt;
    logic [NUM_SRC-1:0] state_q;
    logic               dbg_frz_en;

    frz_state_reg #(.N(NUM_SRC)) u_state (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we),
        .wdata(wdata), .state_nxt(state_nxt), .state_q(state_q)
    );

    frz_dbg_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .dbg_frz_en(dbg_frz_en)
    );

    frz_out_stage #(.N(NUM_SRC), .WDOG_IDX(WDOG_IDX)) u_out (
        .clk(clk), .rst_n(rst_n), .state_nxt(state_nxt), .dbg_halted(dbg_halted),
        .dbg_frz_en(dbg_frz_en), .wdog_nmi_mode(wdog_nmi_mode), .frz_q(frz_out)
    );

    // Purpose: software readback of the stored state.
    always_comb rdata = state_q;

    AST_RDATA_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_halted && !wdog_nmi_mode) |=> (frz_out == rdata)); // R9
endmodule

// File: tb/frz_ctrl_tb.sv
module frz_ctrl_tb;
    localparam int N = 8;
    localparam int WD = 3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         set_we = 1'b0, clr_we = 1'b0, cfg_we = 1'b0, cfg_wdata = 1'b0;
    logic [N-1:0] wdata = '0;
    logic         dbg_halted = 1'b0, wdog_nmi_mode = 1'b0;
    logic [N-1:0] rdata, frz_out;

    int checks = 0;
    int errors = 0;
    logic [N-1:0] m_state = '0;
    logic         m_en = 1'b1;
    logic [N-1:0] m_out = '0;

    always #4 clk = ~clk;

    frz_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .set_we(set_we), .clr_we(clr_we), .wdata(wdata),
        .rdata(rdata), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .dbg_halted(dbg_halted),
        .wdog_nmi_mode(wdog_nmi_mode), .frz_out(frz_out)
    );

    function automatic logic [N-1:0] f_next(logic [N-1:0] s, logic sw, logic cw, logic [N-1:0] d);
        logic [N-1:0] r;
        r = s;
        if (sw) r = r | d;
        if (cw) r = r & ~d;
        return r;
    endfunction

    function automatic logic [N-1:0] f_out(logic [N-1:0] s, logic h, logic en, logic nmi);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) begin
            if (i == WD) r[i] = h | (s[i] & ~nmi);
            else         r[i] = (h & en) | s[i];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Clock one edge with the currently driven inputs, update the model, check at negedge.
    task automatic step(string tag);
        @(posedge clk);
        m_state = f_next(m_state, set_we, clr_we, wdata);
        m_out   = f_out(m_state, dbg_halted, m_en, wdog_nmi_mode);
        if (cfg_we) m_en = cfg_wdata;
        @(negedge clk);
        check({tag, " out R9"}, frz_out, m_out);
        check({tag, " rdata R9"}, rdata, m_state);
    endtask

    task automatic drive(logic sw, logic cw, logic [N-1:0] d, logic h, logic nmi);
        set_we = sw; clr_we = cw; wdata = d; dbg_halted = h; wdog_nmi_mode = nmi; cfg_we = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check("R1 reset out", frz_out, '0);
        check("R1 reset rdata", rdata, '0);
        rst_n = 1'b1;
        // R1: default config bit 1, so a halt freezes everything
        drive(0, 0, 8'h00, 1, 0); step("R1 default halt");
        check("R1 all frozen", frz_out, 8'hFF);
        drive(0, 0, 8'h00, 0, 0); step("R1 release");
        check("R1 after halt", frz_out, 8'h00);
        // R2 / R8: set the DMA bit (5) and timer 0 (1)
        drive(1, 0, 8'b0010_0010, 0, 0); step("R2 set");
        check("R2 R8 dma+tim0", frz_out, 8'b0010_0010);
        drive(1, 0, 8'h00, 0, 0); step("R2 zero set");
        check("R2 zeros ignored", rdata, 8'b0010_0010);
        // R3
        drive(0, 1, 8'h00, 0, 0); step("R3 zero clr");
        check("R3 zeros ignored", rdata, 8'b0010_0010);
        drive(0, 1, 8'b0000_0010, 0, 0); step("R3 clr");
        check("R3 clr tim0", rdata, 8'b0010_0000);
        // R4
        drive(1, 1, 8'b0010_0001, 0, 0); step("R4 both");
        check("R4 clear wins", rdata, 8'b0000_0000);
        // R7: watchdog freeze blocked in NMI mode
        drive(1, 0, 8'b0000_1000, 0, 1); step("R7 nmi");
        check("R7 wdog blocked", frz_out, 8'h00);
        drive(0, 0, 8'h00, 0, 0); step("R7 nmi off");
        check("R7 wdog frozen", frz_out, 8'b0000_1000);
        // R10 / R6: config bit 0, halt freezes only the watchdog
        drive(0, 1, 8'hFF, 0, 0); cfg_we = 1'b1; cfg_wdata = 1'b0; step("R10 cfg");
        drive(1, 0, 8'b1000_0000, 1, 1); step("R6 halt cfg0");
        check("R6 wdog+tim2", frz_out, 8'b1000_1000);
        // R5: config back to 1
        drive(0, 0, 8'h00, 0, 0); cfg_we = 1'b1; cfg_wdata = 1'b1; step("R10 cfg1");
        drive(0, 0, 8'h00, 1, 1); step("R5 halt cfg1");
        check("R5 all", frz_out, 8'hFF);
        // Random mix for R2 R3 R4 R5 R6 R7 R10
        for (int k = 0; k < 400; k++) begin
            drive($urandom_range(0, 1), $urandom_range(0, 1), N'($urandom),
                  ($urandom_range(0, 3) == 0), $urandom_range(0, 1));
            if ($urandom_range(0, 7) == 0) begin
                cfg_we = 1'b1; cfg_wdata = $urandom_range(0, 1);
            end
            step("rand R2 R3 R4 R5 R6 R7 R10");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule